// File: doc/BRIEF.md
# Tile Write-Back CRC Filter

This block sits between a tile buffer and the external-memory writer of a tiled renderer. Once a 16×16 tile is fully rendered, its final pixels stream out of tile storage one 256-bit pixel per cycle. The block folds each pixel into a running CRC-32 signature. At the last pixel it looks up the signature kept for that tile position, which was left there when the same position was finished in an earlier frame. It then tells the writer either to issue the burst (commit) or to drop it (skip). Either way, the fresh signature replaces the stored one, so the next frame compares against the image now held in memory.

Each tile position has one signature entry and a valid bit. Reset clears all the valid bits. A position that has never been finished since reset is therefore always committed. A frame-start pulse abandons any tile still streaming and rearms the accumulator. Tile positions at or above the table size, which are possible only when the table size is not a power of two, are never stored and always commit.

Top module: `twe_top`

## Requirements
- R1: While reset is held, and in the cycles after it until the first decision, `wb_done`, `wb_commit` and `wb_skip` are low. Every table entry is invalid after reset, so the first finished tile at any position commits.
- R2: `wb_crc` is the CRC of the tile's pixels in the order they were accepted. It uses generator 0x04C11DB7 and starts from all ones. Each 256-bit pixel is fed most significant bit first. Nothing is reflected and no final inversion is applied.
- R3: `wb_done` is high for exactly one cycle: the cycle after the accepted pixel that has `pix_last` set. It stays low while a tile is still streaming. `wb_tile` reports the `pix_tile` value that was sampled with the tile's `pix_first` pixel, and `pix_tile` is ignored on every other pixel.
- R4: If the entry for the tile is invalid, the decision is commit (`wb_commit`=1, `wb_skip`=0).
- R5: If the entry is valid and holds a CRC equal to the new one, the decision is skip (`wb_skip`=1, `wb_commit`=0).
- R6: If the entry is valid but holds a different CRC, the decision is commit.
- R7: After every decision, commit or skip, the entry for that tile holds the new CRC and is marked valid. A later tile at that position with the same data therefore skips.
- R8: Entries are kept per position. A tile compares only against its own position's entry, even if another position holds the same CRC.
- R9: `frame_start` takes priority over a pixel presented in the same cycle. It abandons a tile in flight, so no decision is made for that tile and its remaining pixels without `pix_first` are ignored. The next tile's CRC starts again from all ones, and the table is left untouched.
- R10: Cycles with `pix_valid` low leave the CRC, the table and the outputs unchanged, whatever the other pixel inputs hold.
- R11: While `wb_done` is high, exactly one of `wb_commit` and `wb_skip` is high. While it is low, both are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Frame boundary pulse; abandons a tile in flight |
| pix_valid | input | 1 | A pixel is presented this cycle |
| pix_first | input | 1 | Presented pixel is the first of a tile |
| pix_last | input | 1 | Presented pixel is the last of a tile |
| pix_tile | input | IDX_W | Tile position, sampled with the first pixel |
| pix_data | input | PIX_W | Final pixel contents from tile storage |
| wb_done | output | 1 | One-cycle decision strobe |
| wb_commit | output | 1 | Write the tile to external memory |
| wb_skip | output | 1 | Tile unchanged; suppress the write |
| wb_tile | output | IDX_W | Tile position the decision belongs to |
| wb_crc | output | CRC_W | Signature of the finished tile |

## Verification
The checker assumes that every tile sent with `pix_first` carries exactly 256 accepted pixels and that the last of them, and only that one, has `pix_last` set. It also assumes that `frame_start` comes only between tiles or as a deliberate abort. The bench keeps to these rules: each tile is sent as a full raster of 256 pixels, with idle cycles, junk marker values and a wrong tile index placed only in cycles where `pix_valid` is low or `pix_first` is clear. The one exception is the abort case, where `frame_start` falls on a pixel marked last. The pixels that follow it, sent without `pix_first`, are outside any tile the checker counts.

// File: rtl/twe_pkg.sv
package twe_pkg;

   localparam int unsigned         SIG_W_DEF    = 32;
   localparam logic [31:0]         SIG_POLY_DEF = 32'h04C1_1DB7;
   localparam logic [31:0]         SIG_SEED_DEF = 32'hFFFF_FFFF;

   typedef enum logic [1:0] {
      WB_IDLE   = 2'd0,
      WB_COMMIT = 2'd1,
      WB_SKIP   = 2'd2
   } wb_dec_e;

endpackage

// File: rtl/twe_crc_acc.sv
module twe_crc_acc #(
   parameter int unsigned       DATA_W    = 256,
   parameter int unsigned       CRC_W     = 32,
   parameter logic [CRC_W-1:0]  POLY      = 32'h04C1_1DB7,
   parameter logic [CRC_W-1:0]  SEED      = '1,
   parameter int unsigned       BIT_ORDER = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              en,
   input  logic              first,
   input  logic [DATA_W-1:0] in_data,
   output logic [CRC_W-1:0]  crc_next
);

   if (BIT_ORDER > 1) begin : g_bad_order
      $error("twe_crc_acc: BIT_ORDER must be 0 (msb first) or 1 (lsb first)");
   end

   logic [DATA_W-1:0] ord_data;
   logic [CRC_W-1:0]  crc_q;
   logic [CRC_W-1:0]  base;

   if (BIT_ORDER == 0) begin : g_msb
      assign ord_data = in_data;
   end else begin : g_lsb
      for (genvar b = 0; b < DATA_W; b++) begin : g_rev
         assign ord_data[b] = in_data[DATA_W-1-b];
      end
   end

   function automatic logic [CRC_W-1:0] fold(input logic [CRC_W-1:0] c_in,
                                              input logic [DATA_W-1:0] d);
      logic [CRC_W-1:0] c;
      c = c_in;
      for (int i = DATA_W - 1; i >= 0; i--) begin
         c = (c << 1) ^ (((c[CRC_W-1] ^ d[i]) == 1'b1) ? POLY : '0);
      end
      return c;
   endfunction

   assign base     = first ? SEED : crc_q;
   assign crc_next = fold(base, ord_data);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         crc_q <= SEED;
      end else if (clr) begin
         crc_q <= SEED;
      end else if (en) begin
         crc_q <= crc_next;
      end
   end

endmodule

// File: rtl/twe_sig_table.sv
module twe_sig_table #(
   parameter int unsigned N     = 64,
   parameter int unsigned IDX_W = 6,
   parameter int unsigned CRC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_valid,
   output logic [CRC_W-1:0] rd_crc,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [CRC_W-1:0] wr_crc,
   output logic [N-1:0]     valid_vec
);

   localparam bit FULL_MAP = (N == (1 << IDX_W));

   if (N > (1 << IDX_W)) begin : g_bad_idx
      $error("twe_sig_table: IDX_W too narrow for N");
   end

   logic [N-1:0]     vld_q;
   logic [CRC_W-1:0] sig_mem [N];
   logic             rd_in_map;
   logic             wr_in_map;

   if (FULL_MAP) begin : g_full
      assign rd_in_map = 1'b1;
      assign wr_in_map = 1'b1;
   end else begin : g_part
      assign rd_in_map = (32'(rd_idx) < N);
      assign wr_in_map = (32'(wr_idx) < N);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else if (wr_en && wr_in_map) begin
         vld_q[wr_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en && wr_in_map) begin
         sig_mem[wr_idx] <= wr_crc;
      end
   end

   assign rd_valid  = rd_in_map && vld_q[rd_idx];
   assign rd_crc    = rd_in_map ? sig_mem[rd_idx] : '0;
   assign valid_vec = vld_q;

endmodule

// File: rtl/twe_decide.sv
module twe_decide
   import twe_pkg::*;
#(
   parameter int unsigned CRC_W = 32,
   parameter int unsigned IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fin,
   input  logic [CRC_W-1:0] fin_crc,
   input  logic [IDX_W-1:0] fin_idx,
   input  logic             ref_valid,
   input  logic [CRC_W-1:0] ref_crc,
   output logic             done,
   output logic             commit,
   output logic             skip,
   output logic [IDX_W-1:0] tile,
   output logic [CRC_W-1:0] crc
);

   wb_dec_e          dec_d;
   wb_dec_e          dec_q;
   logic [IDX_W-1:0] tile_q;
   logic [CRC_W-1:0] crc_q;

   always_comb begin
      dec_d = WB_IDLE;
      if (fin) begin
         dec_d = (ref_valid && (ref_crc == fin_crc)) ? WB_SKIP : WB_COMMIT;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dec_q  <= WB_IDLE;
         tile_q <= '0;
         crc_q  <= '0;
      end else begin
         dec_q <= dec_d;
         if (fin) begin
            tile_q <= fin_idx;
            crc_q  <= fin_crc;
         end
      end
   end

   assign done   = (dec_q != WB_IDLE);
   assign commit = (dec_q == WB_COMMIT);
   assign skip   = (dec_q == WB_SKIP);
   assign tile   = tile_q;
   assign crc    = crc_q;

endmodule

// File: rtl/twe_top.sv
module twe_top #(
   parameter int unsigned      TILE_DIM  = 16,
   parameter int unsigned      PIX_W     = 256,
   parameter int unsigned      N_TILES   = 64,
   parameter int unsigned      CRC_W     = twe_pkg::SIG_W_DEF,
   parameter logic [CRC_W-1:0] CRC_POLY  = twe_pkg::SIG_POLY_DEF,
   parameter logic [CRC_W-1:0] CRC_SEED  = twe_pkg::SIG_SEED_DEF,
   parameter int unsigned      BIT_ORDER = 0,
   localparam int unsigned     TILE_PIX  = TILE_DIM * TILE_DIM,
   localparam int unsigned     IDX_W     = (N_TILES > 1) ? $clog2(N_TILES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_start,
   input  logic             pix_valid,
   input  logic             pix_first,
   input  logic             pix_last,
   input  logic [IDX_W-1:0] pix_tile,
   input  logic [PIX_W-1:0] pix_data,
   output logic             wb_done,
   output logic             wb_commit,
   output logic             wb_skip,
   output logic [IDX_W-1:0] wb_tile,
   output logic [CRC_W-1:0] wb_crc
);

   if (TILE_DIM < 2 || TILE_PIX > 65536) begin : g_bad_dim
      $error("twe_top: TILE_DIM out of range");
   end
   if (CRC_W < 8 || CRC_W > 64) begin : g_bad_crc_w
      $error("twe_top: CRC_W must be 8..64");
   end
   if (CRC_POLY[0] != 1'b1) begin : g_bad_poly
      $error("twe_top: generator must have its constant term set");
   end
   if (N_TILES < 1 || PIX_W < 1) begin : g_bad_size
      $error("twe_top: N_TILES and PIX_W must be positive");
   end

   logic             acc_en;
   logic             fin;
   logic             in_tile_q;
   logic [IDX_W-1:0] cur_idx_q;
   logic [IDX_W-1:0] lk_idx;
   logic [CRC_W-1:0] tile_crc;
   logic             lk_valid;
   logic [CRC_W-1:0] lk_crc;
   logic [N_TILES-1:0] ent_valid;

   assign acc_en = pix_valid && !frame_start && (pix_first || in_tile_q);
   assign fin    = acc_en && pix_last;
   assign lk_idx = pix_first ? pix_tile : cur_idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_tile_q <= 1'b0;
         cur_idx_q <= '0;
      end else if (frame_start) begin
         in_tile_q <= 1'b0;
      end else if (acc_en) begin
         in_tile_q <= !pix_last;
         if (pix_first) begin
            cur_idx_q <= pix_tile;
         end
      end
   end

   twe_crc_acc #(
      .DATA_W    (PIX_W),
      .CRC_W     (CRC_W),
      .POLY      (CRC_POLY),
      .SEED      (CRC_SEED),
      .BIT_ORDER (BIT_ORDER)
   ) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (frame_start),
      .en       (acc_en),
      .first    (pix_first),
      .in_data  (pix_data),
      .crc_next (tile_crc)
   );

   twe_sig_table #(
      .N     (N_TILES),
      .IDX_W (IDX_W),
      .CRC_W (CRC_W)
   ) u_tab (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_idx    (lk_idx),
      .rd_valid  (lk_valid),
      .rd_crc    (lk_crc),
      .wr_en     (fin),
      .wr_idx    (lk_idx),
      .wr_crc    (tile_crc),
      .valid_vec (ent_valid)
   );

   twe_decide #(
      .CRC_W (CRC_W),
      .IDX_W (IDX_W)
   ) u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .fin       (fin),
      .fin_crc   (tile_crc),
      .fin_idx   (lk_idx),
      .ref_valid (lk_valid),
      .ref_crc   (lk_crc),
      .done      (wb_done),
      .commit    (wb_commit),
      .skip      (wb_skip),
      .tile      (wb_tile),
      .crc       (wb_crc)
   );

endmodule

// File: rtl/twe_chk.sv
module twe_chk #(
   parameter int unsigned N_TILES  = 64,
   parameter int unsigned IDX_W    = 6,
   parameter int unsigned TILE_PIX = 256
) (
   input logic               clk,
   input logic               rst_n,
   input logic               frame_start,
   input logic               pix_valid,
   input logic               pix_first,
   input logic               pix_last,
   input logic               wb_done,
   input logic               wb_commit,
   input logic               wb_skip,
   input logic [IDX_W-1:0]   wb_tile,
   input logic [N_TILES-1:0] ent_valid,
   input logic               lk_valid,
   input logic               in_tile
);

   localparam int unsigned CNT_W = $clog2(TILE_PIX) + 1;

   logic             armed;
   logic [CNT_W-1:0] pix_cnt;
   logic             accepted;

   assign accepted = pix_valid && !frame_start && (pix_first || in_tile);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed   <= 1'b0;
         pix_cnt <= '0;
      end else begin
         armed <= 1'b1;
         if (accepted) begin
            pix_cnt <= pix_first ? CNT_W'(1) : pix_cnt + CNT_W'(1);
         end
      end
   end

   // R1
   reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |-> (ent_valid == '0 && !wb_done && !wb_commit && !wb_skip));

   // R3
   tile_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accepted && pix_last && !pix_first) |-> (32'(pix_cnt) == TILE_PIX - 1));

   // R3
   done_timing_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      wb_done == $past(accepted && pix_last));

   // R4
   miss_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accepted && pix_last && !lk_valid) |=> wb_commit);

   // R7
   entry_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_done |-> ent_valid[wb_tile]);

   // R9
   abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> !wb_done);

   // R11
   one_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_done |-> ($countones({wb_commit, wb_skip}) == 1));

   // R11
   idle_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wb_done |-> (!wb_commit && !wb_skip));

endmodule

bind twe_top twe_chk #(
   .N_TILES  (N_TILES),
   .IDX_W    (IDX_W),
   .TILE_PIX (TILE_PIX)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .frame_start (frame_start),
   .pix_valid   (pix_valid),
   .pix_first   (pix_first),
   .pix_last    (pix_last),
   .wb_done     (wb_done),
   .wb_commit   (wb_commit),
   .wb_skip     (wb_skip),
   .wb_tile     (wb_tile),
   .ent_valid   (ent_valid),
   .lk_valid    (lk_valid),
   .in_tile     (in_tile_q)
);

// File: tb/tb_twe_top.sv
module tb_twe_top;

   localparam int TP  = 256;
   localparam int NT  = 4;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         frame_start;
   logic         pix_valid;
   logic         pix_first;
   logic         pix_last;
   logic [1:0]   pix_tile;
   logic [255:0] pix_data;
   logic         wb_done;
   logic         wb_commit;
   logic         wb_skip;
   logic [1:0]   wb_tile;
   logic [31:0]  wb_crc;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   logic        m_valid [NT];
   logic [31:0] m_crc   [NT];

   always #2 clk = ~clk;

   twe_top #(.N_TILES(NT)) dut (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
      .pix_valid(pix_valid), .pix_first(pix_first), .pix_last(pix_last),
      .pix_tile(pix_tile), .pix_data(pix_data),
      .wb_done(wb_done), .wb_commit(wb_commit), .wb_skip(wb_skip),
      .wb_tile(wb_tile), .wb_crc(wb_crc)
   );

   function automatic logic [31:0] ref_crc(input logic [31:0] c_in, input logic [255:0] d);
      logic [31:0] c;
      c = c_in;
      for (int i = 255; i >= 0; i--) begin
         logic fb;
         fb = c[31] ^ d[i];
         c  = {c[30:0], 1'b0};
         if (fb) c = c ^ 32'h04C1_1DB7;
      end
      return c;
   endfunction

   function automatic logic [255:0] pix(input int seed, input int k);
      logic [255:0] r;
      for (int j = 0; j < 8; j++) begin
         logic [31:0] w;
         w = 32'(seed) * 32'h0100_0193 + 32'(k) * 32'h9E37_79B9 + 32'(j) * 32'h7F4A_7C15;
         r[j*32 +: 32] = w ^ (32'(seed) << j);
      end
      return r;
   endfunction

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic idle();
      pix_valid = 1'b0; pix_first = 1'b0; pix_last = 1'b0;
      frame_start = 1'b0;
   endtask

   task automatic pulse_frame();
      idle();
      frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
      chk("R9", "done after frame_start", 64'(wb_done), 64'd0);
   endtask

   // Streams npix pixels of a tile; a full tile ends with pix_last.
   task automatic send_tile(input int idx, input int seed, input bit gaps, input int npix,
                            output logic [31:0] crc);
      crc = 32'hFFFF_FFFF;
      for (int k = 0; k < npix; k++) begin
         if (gaps && (k % 7 == 3)) begin
            pix_valid = 1'b0; pix_first = 1'b1; pix_last = 1'b1;
            pix_data = '1; pix_tile = 2'(~idx);
            @(negedge clk);
         end
         pix_valid = 1'b1;
         pix_first = (k == 0);
         pix_last  = (k == TP - 1);
         pix_tile  = (k == 0) ? 2'(idx) : 2'(~idx);
         pix_data  = pix(seed, k);
         crc = ref_crc(crc, pix_data);
         @(negedge clk);
         if (k == TP / 2) chk("R3", "done during tile", 64'(wb_done), 64'd0);
      end
      idle();
   endtask

   task automatic check_decision(input int idx, input logic [31:0] crc, output logic got_commit);
      bit    hit;
      string req;
      hit = m_valid[idx] && (m_crc[idx] == crc);
      req = !m_valid[idx] ? "R4" : (hit ? "R5" : "R6");
      chk("R3", "done strobe", 64'(wb_done), 64'd1);
      chk("R3", "tile index", 64'(wb_tile), 64'(idx));
      chk("R2", "crc value", 64'(wb_crc), 64'(crc));
      chk(req, "commit", 64'(wb_commit), 64'(!hit));
      chk(req, "skip", 64'(wb_skip), 64'(hit));
      chk("R11", "one decision", 64'(wb_commit ^ wb_skip), 64'd1);
      got_commit = wb_commit;
      m_valid[idx] = 1'b1;
      m_crc[idx]   = crc;
      @(negedge clk);
      chk("R3", "single-cycle done", 64'(wb_done), 64'd0);
      chk("R11", "idle decision", 64'({wb_commit, wb_skip}), 64'd0);
   endtask

   task automatic tile_round(input int idx, input int seed, input bit gaps, output logic got_commit,
                             output logic [31:0] crc);
      send_tile(idx, seed, gaps, TP, crc);
      check_decision(idx, crc, got_commit);
   endtask

   initial begin
      logic        gc;
      logic [31:0] c;
      rst_n = 1'b0; pix_tile = '0; pix_data = '0;
      idle();
      for (int i = 0; i < NT; i++) begin m_valid[i] = 1'b0; m_crc[i] = '0; end
      repeat (4) @(negedge clk);
      chk("R1", "done in reset", 64'(wb_done), 64'd0);
      chk("R1", "commit/skip in reset", 64'({wb_commit, wb_skip}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "done after reset", 64'(wb_done), 64'd0);

      // frame 1: every position is new
      pulse_frame();
      for (int t = 0; t < NT; t++) begin
         tile_round(t, 10 + t, 1'b0, gc, c);
         chk("R1", "first frame commits", 64'(gc), 64'd1);
      end

      // frame 2: unchanged, stalled, changed
      pulse_frame();
      tile_round(0, 10, 1'b0, gc, c);
      tile_round(1, 11, 1'b1, gc, c);
      chk("R10", "stalls leave skip intact", 64'(gc), 64'd0);
      tile_round(2, 99, 1'b0, gc, c);
      tile_round(3, 13, 1'b0, gc, c);

      // frame 3: stored-after-commit, per-position entries
      pulse_frame();
      tile_round(2, 99, 1'b0, gc, c);
      chk("R7", "updated entry skips", 64'(gc), 64'd0);
      tile_round(3, 10, 1'b0, gc, c);
      chk("R8", "other position's crc ignored", 64'(gc), 64'd1);
      tile_round(3, 10, 1'b1, gc, c);
      chk("R7", "entry replaced after commit", 64'(gc), 64'd0);

      // abort: frame_start over a last pixel, then orphan pixels
      send_tile(1, 55, 1'b0, 100, c);
      pix_valid = 1'b1; pix_first = 1'b0; pix_last = 1'b1; pix_data = pix(55, 100);
      frame_start = 1'b1;
      @(negedge clk);
      idle();
      chk("R9", "no decision on abort", 64'(wb_done), 64'd0);
      for (int k = 0; k < 30; k++) begin
         pix_valid = 1'b1; pix_first = 1'b0; pix_last = (k == 29);
         pix_data = pix(55, 101 + k);
         @(negedge clk);
      end
      idle();
      @(negedge clk);
      chk("R9", "orphan pixels ignored", 64'(wb_done), 64'd0);
      tile_round(1, 11, 1'b0, gc, c);
      chk("R9", "restart from seed skips", 64'(gc), 64'd0);

      // reset again: table forgotten
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < NT; i++) m_valid[i] = 1'b0;
      @(negedge clk);
      tile_round(0, 10, 1'b0, gc, c);
      chk("R1", "commit after reset", 64'(gc), 64'd1);
      tile_round(0, 10, 1'b0, gc, c);
      chk("R5", "repeat skips", 64'(gc), 64'd0);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog run did not complete actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule